// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds a small set of general-purpose data registers. Software-visible instructions treat each register either as one 16-bit word or as two independent 8-bit halves. The halves are not separate storage: they are views of the same word. A byte write therefore merges into the stored word and leaves the other half as it was. A word read after a byte write shows the merged value.

The file has one write port and two read ports. Each port carries a register index, a size select (word or byte) and a half select. A byte read presents the chosen half on the low bits of the 16-bit read bus with the upper bits forced to zero.

Reads are purely combinational. Writes take effect on the rising clock edge. A synchronous reset clears every register.

Top module: `gpr_bytefile`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to 0000h, so every read after that edge returns zero.
- R2: With `wr_en`=1 and `wr_byte`=0, the whole of `wr_data` is stored into register `wr_idx` at the rising edge.
- R3: With `wr_en`=1, `wr_byte`=1 and `wr_hi`=1, bits 15:8 of register `wr_idx` take `wr_data[7:0]` at the rising edge, and bits 7:0 keep their previous value.
- R4: With `wr_en`=1, `wr_byte`=1 and `wr_hi`=0, bits 7:0 of register `wr_idx` take `wr_data[7:0]` at the rising edge, and bits 15:8 keep their previous value.
- R5: A read with size select 0 (word) returns all 16 bits of the indexed register.
- R6: A read with size select 1 (byte) returns the high half (half select 1) or the low half (half select 0) on bits 7:0, with bits 15:8 equal to zero.
- R7: Reads are combinational. A read of the register being written in the same cycle returns the old value until the rising edge.
- R8: When `wr_en`=0 no register changes. A write changes only the register selected by `wr_idx`.
- R9: Index values 0, 1, 2 and 3 select four distinct registers, in the roles accumulator, count, data and base respectively. The two read ports select and format their data independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 2 | Register index for the write |
| wr_byte | input | 1 | Write size: 0 word, 1 byte |
| wr_hi | input | 1 | Byte write half: 1 high, 0 low |
| wr_data | input | 16 | Write data; bits 7:0 are used for byte writes |
| rd0_idx | input | 2 | Register index for read port 0 |
| rd0_byte | input | 1 | Read port 0 size: 0 word, 1 byte |
| rd0_hi | input | 1 | Read port 0 half: 1 high, 0 low |
| rd0_data | output | 16 | Read port 0 data, zero-extended for byte reads |
| rd1_idx | input | 2 | Register index for read port 1 |
| rd1_byte | input | 1 | Read port 1 size: 0 word, 1 byte |
| rd1_hi | input | 1 | Read port 1 half: 1 high, 0 low |
| rd1_data | output | 16 | Read port 1 data, zero-extended for byte reads |

## Verification
The bench builds the block with its default parameters: four registers of 16 bits, which gives 8-bit halves and a 2-bit index. These values reach every index code and both halves of every register. They also cover the boundary between the halves, where a high-byte write must not disturb bit 7 and a low-byte write must not disturb bit 8. The bench uses all-ones and alternating patterns so that any leak across that boundary, or into the zero-extended upper read bits, shows up.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    // Access size encoding shared by the write and read ports
    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_BYTE = 1'b1
    } size_e;

    // Half encoding used when the size is byte
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/gpr_merge.sv
// Next-value logic for one register: merges a word or a byte write into the held word.
module gpr_merge #(
    parameter int WORD_W = 16
) (
    input  logic              hit,
    input  logic              byte_sel,
    input  logic              hi_sel,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] new_word
);
    import gpr_pkg::*;

    localparam int HALF_W = WORD_W / 2;

    always_comb begin
        new_word = old_word;
        if (hit) begin
            if (size_e'(byte_sel) == SZ_WORD) begin
                new_word = wdata;
            end else if (half_e'(hi_sel) == HALF_HI) begin
                new_word[WORD_W-1:HALF_W] = wdata[HALF_W-1:0];
            end else begin
                new_word[HALF_W-1:0] = wdata[HALF_W-1:0];
            end
        end
    end
endmodule

// File: rtl/gpr_view.sv
// One read port: picks a register and formats it as a word or a zero-extended half.
module gpr_view #(
    parameter int NUM_REGS = 4,
    parameter int WORD_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][WORD_W-1:0] regs,
    input  logic [IDX_W-1:0]                idx,
    input  logic                            byte_sel,
    input  logic                            hi_sel,
    output logic [WORD_W-1:0]               rdata
);
    import gpr_pkg::*;

    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] sel_word;

    always_comb begin
        sel_word = regs[idx];
        rdata    = '0;
        if (size_e'(byte_sel) == SZ_WORD) begin
            rdata = sel_word;
        end else if (half_e'(hi_sel) == HALF_HI) begin
            rdata[HALF_W-1:0] = sel_word[WORD_W-1:HALF_W];
        end else begin
            rdata[HALF_W-1:0] = sel_word[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/gpr_bytefile.sv
module gpr_bytefile #(
    parameter int NUM_REGS = 4,
    parameter int WORD_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_byte,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic              rd0_byte,
    input  logic              rd0_hi,
    output logic [WORD_W-1:0] rd0_data,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic              rd1_byte,
    input  logic              rd1_hi,
    output logic [WORD_W-1:0] rd1_data
);
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] regs;
    } state_t;

    state_t state_d, state_q;
    logic [NUM_REGS-1:0][WORD_W-1:0] merged;

    // Per-register merge units
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        gpr_merge #(.WORD_W(WORD_W)) u_merge (
            .hit      (wr_en && (wr_idx == IDX_W'(k))),
            .byte_sel (wr_byte),
            .hi_sel   (wr_hi),
            .old_word (state_q.regs[k]),
            .wdata    (wr_data),
            .new_word (merged[k])
        );

        // R2
        word_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wr_byte && wr_idx == IDX_W'(k)) |=> state_q.regs[k] == $past(wr_data));

        // R3
        hi_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_byte && wr_hi && wr_idx == IDX_W'(k)) |=>
            (state_q.regs[k][WORD_W-1:HALF_W] == $past(wr_data[HALF_W-1:0]) &&
             state_q.regs[k][HALF_W-1:0] == $past(state_q.regs[k][HALF_W-1:0])));

        // R4
        lo_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_byte && !wr_hi && wr_idx == IDX_W'(k)) |=>
            (state_q.regs[k][HALF_W-1:0] == $past(wr_data[HALF_W-1:0]) &&
             state_q.regs[k][WORD_W-1:HALF_W] == $past(state_q.regs[k][WORD_W-1:HALF_W])));

        // R8
        untouched_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == IDX_W'(k)) |=> $stable(state_q.regs[k]));

        // R1
        reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> state_q.regs[k] == '0);
    end

    // Next-state computation
    always_comb begin
        state_d      = state_q;
        state_d.regs = merged;
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    gpr_view #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_view0 (
        .regs     (state_q.regs),
        .idx      (rd0_idx),
        .byte_sel (rd0_byte),
        .hi_sel   (rd0_hi),
        .rdata    (rd0_data)
    );

    gpr_view #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_view1 (
        .regs     (state_q.regs),
        .idx      (rd1_idx),
        .byte_sel (rd1_byte),
        .hi_sel   (rd1_hi),
        .rdata    (rd1_data)
    );

    // R6
    rd0_zext_chk: assert property (@(posedge clk) disable iff (rst)
        rd0_byte |-> rd0_data[WORD_W-1:HALF_W] == '0);

    // R6
    rd1_zext_chk: assert property (@(posedge clk) disable iff (rst)
        rd1_byte |-> rd1_data[WORD_W-1:HALF_W] == '0);

    // R5
    rd_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd0_byte && !rd1_byte && rd0_idx == rd1_idx) |-> rd0_data == rd1_data);
endmodule

// File: tb/gpr_bytefile_tb.sv
module gpr_bytefile_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_idx;
    logic        wr_byte;
    logic        wr_hi;
    logic [15:0] wr_data;
    logic [1:0]  rd0_idx;
    logic        rd0_byte;
    logic        rd0_hi;
    logic [15:0] rd0_data;
    logic [1:0]  rd1_idx;
    logic        rd1_byte;
    logic        rd1_hi;
    logic [15:0] rd1_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpr_bytefile u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte),
        .wr_hi(wr_hi), .wr_data(wr_data),
        .rd0_idx(rd0_idx), .rd0_byte(rd0_byte), .rd0_hi(rd0_hi), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_byte(rd1_byte), .rd1_hi(rd1_hi), .rd1_data(rd1_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic bsel, input logic hsel, input logic [15:0] d);
        @(negedge clk);
        wr_idx = idx; wr_byte = bsel; wr_hi = hsel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd0(input logic [1:0] idx, input logic bsel, input logic hsel, output logic [15:0] d);
        rd0_idx = idx; rd0_byte = bsel; rd0_hi = hsel;
        #1 d = rd0_data;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            rd0(2'(i), 1'b0, 1'b0, d);
            chk("R1 reset clears", d, 16'h0000);
        end
    endtask

    task automatic t_word;
        logic [15:0] d;
        wr(2'd0, 1'b0, 1'b0, 16'hA55A);
        rd0(2'd0, 1'b0, 1'b0, d);
        chk("R2 R5 word write/read", d, 16'hA55A);
    endtask

    task automatic t_hi_merge;
        logic [15:0] d;
        wr(2'd0, 1'b1, 1'b1, 16'hFF3F);
        rd0(2'd0, 1'b0, 1'b0, d);
        chk("R3 high byte merge", d, 16'h3F5A);
    endtask

    task automatic t_lo_merge;
        logic [15:0] d;
        wr(2'd2, 1'b0, 1'b0, 16'hFFFF);
        wr(2'd2, 1'b1, 1'b0, 16'h1200);
        rd0(2'd2, 1'b0, 1'b0, d);
        chk("R4 low byte merge", d, 16'hFF00);
    endtask

    task automatic t_byte_read;
        logic [15:0] d;
        wr(2'd3, 1'b0, 1'b0, 16'h143E);
        rd0(2'd3, 1'b1, 1'b1, d);
        chk("R6 high byte read", d, 16'h0014);
        rd0(2'd3, 1'b1, 1'b0, d);
        chk("R6 low byte read", d, 16'h003E);
    endtask

    task automatic t_same_cycle;
        logic [15:0] d;
        @(negedge clk);
        wr_idx = 2'd1; wr_byte = 1'b0; wr_hi = 1'b0; wr_data = 16'hBEEF; wr_en = 1'b1;
        rd0(2'd1, 1'b0, 1'b0, d);
        chk("R7 old value before edge", d, 16'h0000);
        @(negedge clk);
        wr_en = 1'b0;
        rd0(2'd1, 1'b0, 1'b0, d);
        chk("R7 new value after edge", d, 16'hBEEF);
    endtask

    task automatic t_no_write;
        logic [15:0] d;
        @(negedge clk);
        wr_idx = 2'd1; wr_byte = 1'b0; wr_data = 16'h0000; wr_en = 1'b0;
        @(negedge clk);
        rd0(2'd1, 1'b0, 1'b0, d);
        chk("R8 disabled write ignored", d, 16'hBEEF);
        rd0(2'd0, 1'b0, 1'b0, d);
        chk("R8 other register kept", d, 16'h3F5A);
    endtask

    task automatic t_index_ports;
        logic [15:0] d;
        wr(2'd0, 1'b0, 1'b0, 16'h1111);
        wr(2'd1, 1'b0, 1'b0, 16'h2222);
        wr(2'd2, 1'b0, 1'b0, 16'h3333);
        wr(2'd3, 1'b0, 1'b0, 16'h4444);
        for (int i = 0; i < 4; i++) begin
            rd0(2'(i), 1'b0, 1'b0, d);
            chk("R9 distinct index", d, 16'(16'h1111 * (i + 1)));
        end
        rd1_idx = 2'd3; rd1_byte = 1'b1; rd1_hi = 1'b0;
        rd0(2'd1, 1'b0, 1'b0, d);
        chk("R9 port0 independent", d, 16'h2222);
        chk("R9 port1 independent", rd1_data, 16'h0044);
    endtask

    task automatic t_reset_again;
        logic [15:0] d;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd0(2'd3, 1'b0, 1'b0, d);
        chk("R1 reset after data", d, 16'h0000);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_byte = 1'b0; wr_hi = 1'b0; wr_data = '0;
        rd0_idx = '0; rd0_byte = 1'b0; rd0_hi = 1'b0;
        rd1_idx = '0; rd1_byte = 1'b0; rd1_hi = 1'b0;
        t_reset();
        t_word();
        t_hi_merge();
        t_lo_merge();
        t_byte_read();
        t_same_cycle();
        t_no_write();
        t_index_ports();
        t_reset_again();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule